// File: doc/BRIEF.md
# I2C Multi-Address Target Controller

This block is the target side of an I2C bus. A system clock much faster than the bus samples SCL and SDA. Each line passes through a two-flop synchroniser and a three-sample agreement filter. Edges, START, repeated START and STOP are detected on the filtered levels. The block compares each address byte with four programmable address slots, each with its own don't-care mask. It can also answer the general call address. The direction bit of the address byte puts the block into receive or transmit mode.

Software drives the block through a small synchronous register port. A control register holds the enable, acknowledge-enable and interrupt-flag bits. It is written through a set location and a clear location. After every protocol event the flag rises and a status code shows what happened. After a byte event the block also holds SCL low until software clears the flag. Whether the block acknowledges is decided by a software bit.

Register map (byte wide): 0 control set (write 1 to set, read returns control), 1 control clear (write 1 to clear), 2 status, 3 data, 4..7 address slots 0..3, 8..11 mask slots 0..3.

Top module: `i2c_multi_target`

## Requirements
- R1: After reset, SCL and SDA are released, `irq` is 0, the control register reads 0x00 and the status register reads 0xF8.
- R2: A low pulse on SDA of two system clocks while SCL is high is not taken as a START. Address bits clocked afterwards without a real START get no acknowledge, and the status stays 0xF8.
- R3: An address slot stores the 7-bit address in bits 7:1. A mask slot bit 7:1 set to 1 makes that address bit a don't-care. An address byte that matches any slot with direction 0 is acknowledged (SDA low in the ninth clock), sets the flag and reports status 0x60.
- R4: An address byte that matches no slot, and is not an accepted general call, is not acknowledged. The flag stays 0 and the status stays 0xF8.
- R5: The byte 0x00 is acknowledged as general call with status 0x70 only while bit 0 of at least one address slot is 1. A data byte acknowledged after it reports 0x90 (0x98 if not acknowledged).
- R6: In receive mode each data byte appears at the data register. With control bit 2 (acknowledge-enable) at 1 it is acknowledged and reports 0x80. With that bit at 0 SDA stays high and it reports 0x88.
- R7: A direction bit of 1 reports 0x A8 after the address. The data register byte is then shifted out most significant bit first. A master acknowledge reports 0xB8 and a master not-acknowledge reports 0xC0.
- R8: After an address or data byte event, `scl_oe` stays 1 while the flag is set. Writing 1 to bit 3 of the clear location drops the flag, releases SCL and returns the status to 0xF8.
- R9: A STOP or repeated START while addressed sets the flag with status 0xA0 without holding SCL. A STOP after the block stopped being addressed (after 0x88 or 0xC0) sets nothing.
- R10: With control bit 6 (enable) at 0, or control bit 2 at 0, no address is acknowledged and the bus lines stay released.
- R11: Writing the set location sets control bits 6, 5, 4 and 2 where the written bit is 1, but never sets bit 3 (the flag). Writing the clear location clears the bits written as 1.
- R12: The block changes its SDA drive only while SCL is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, much faster than SCL |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | SCL line level |
| sda_i | input | 1 | SDA line level |
| scl_oe | output | 1 | 1 pulls SCL low (clock stretch) |
| sda_oe | output | 1 | 1 pulls SDA low (acknowledge or data 0) |
| reg_addr | input | REG_AW | Register index |
| reg_we | input | 1 | Write strobe for one clock |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data of the indexed register (combinational) |
| irq | output | 1 | Interrupt flag, equal to control bit 3 |

## Verification
Address matching is tried with several address bytes. One is an exact hit on an unmasked slot. Two others differ only in masked bits of another slot, and one differs in an unmasked bit. Together these separate the mask polarity from plain equality. The zero address is sent twice, once with general call enabled and once with it disabled, to show that the slot bit 0 gate is honoured. Receive bytes are sent with acknowledge-enable on and off, and transmit bytes are ended with a master acknowledge and with a not-acknowledge. These pairs check both branches of every status pair. A short SDA glitch followed by clocked bits without a START shows that the filter rejects noise and that matching needs a real START.

// File: rtl/i2cs_pkg.sv
package i2cs_pkg;
   typedef enum logic [2:0] {
      ST_IDLE, ST_ADDR, ST_ADDR_ACK, ST_RX, ST_RX_ACK, ST_TX_LOAD, ST_TX, ST_TX_ACK
   } bus_state_e;

   localparam logic [7:0] STAT_NONE       = 8'hF8;
   localparam logic [7:0] STAT_OWN_W      = 8'h60;
   localparam logic [7:0] STAT_GC         = 8'h70;
   localparam logic [7:0] STAT_RX_ACK     = 8'h80;
   localparam logic [7:0] STAT_RX_NACK    = 8'h88;
   localparam logic [7:0] STAT_GC_RX_ACK  = 8'h90;
   localparam logic [7:0] STAT_GC_RX_NACK = 8'h98;
   localparam logic [7:0] STAT_STOP       = 8'hA0;
   localparam logic [7:0] STAT_OWN_R      = 8'hA8;
   localparam logic [7:0] STAT_TX_ACK     = 8'hB8;
   localparam logic [7:0] STAT_TX_NACK    = 8'hC0;

   localparam int CTL_EN  = 6;
   localparam int CTL_STA = 5;
   localparam int CTL_STO = 4;
   localparam int CTL_SI  = 3;
   localparam int CTL_AA  = 2;

   localparam int REG_CSET  = 0;
   localparam int REG_CCLR  = 1;
   localparam int REG_STAT  = 2;
   localparam int REG_DATA  = 3;
   localparam int REG_SLOT0 = 4;
endpackage

// File: rtl/i2cs_line_filter.sv
module i2cs_line_filter #(
   parameter int SYNC_STAGES = 2,
   parameter int FILT_LEN    = 3
) (
   input  logic clk,
   input  logic rst_n,
   input  logic pin_i,
   output logic level_o
);
   generate
      if (SYNC_STAGES < 2 || FILT_LEN < 1) begin : g_bad_cfg
         $error("i2cs_line_filter: SYNC_STAGES must be >= 2 and FILT_LEN >= 1");
      end
   endgenerate

   logic [SYNC_STAGES-1:0] sync_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) sync_q <= '1;
      else        sync_q <= {sync_q[SYNC_STAGES-2:0], pin_i};
   end

   generate
      if (FILT_LEN == 1) begin : g_nofilt
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) level_o <= 1'b1;
            else        level_o <= sync_q[SYNC_STAGES-1];
         end
      end else begin : g_filt
         logic [FILT_LEN-1:0] win_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               win_q   <= '1;
               level_o <= 1'b1;
            end else begin
               win_q <= {win_q[FILT_LEN-2:0], sync_q[SYNC_STAGES-1]};
               if (&win_q)       level_o <= 1'b1;
               else if (~|win_q) level_o <= 1'b0;
            end
         end
      end
   endgenerate
endmodule

// File: rtl/i2cs_addr_match.sv
module i2cs_addr_match #(
   parameter int NUM_SLOTS = 4
) (
   input  logic [7:0]                  rx_byte,
   input  logic [NUM_SLOTS-1:0][7:0]   slot_addr,
   input  logic [NUM_SLOTS-1:0][6:0]   slot_mask,
   output logic                        own_hit,
   output logic                        gc_hit
);
   logic [NUM_SLOTS-1:0] slot_hit;
   logic [NUM_SLOTS-1:0] slot_gc;

   for (genvar i = 0; i < NUM_SLOTS; i++) begin : g_slot
      assign slot_hit[i] = ((rx_byte[7:1] ^ slot_addr[i][7:1]) & ~slot_mask[i]) == 7'd0;
      assign slot_gc[i]  = slot_addr[i][0];
   end

   assign own_hit = |slot_hit;
   assign gc_hit  = (rx_byte == 8'h00) && (|slot_gc);
endmodule

// File: rtl/i2c_multi_target.sv
module i2c_multi_target
   import i2cs_pkg::*;
#(
   parameter int NUM_SLOTS   = 4,
   parameter int SYNC_STAGES = 2,
   parameter int FILT_LEN    = 3,
   parameter int REG_AW      = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              scl_i,
   input  logic              sda_i,
   output logic              scl_oe,
   output logic              sda_oe,
   input  logic [REG_AW-1:0] reg_addr,
   input  logic              reg_we,
   input  logic [7:0]        reg_wdata,
   output logic [7:0]        reg_rdata,
   output logic              irq
);
   localparam int NUM_REGS = REG_SLOT0 + 2 * NUM_SLOTS;

   generate
      if (NUM_SLOTS < 1 || NUM_REGS > (1 << REG_AW)) begin : g_bad_cfg
         $error("i2c_multi_target: register map does not fit REG_AW");
      end
   endgenerate

   // line conditioning and condition detection
   logic scl_f, sda_f, scl_d, sda_d;

   i2cs_line_filter #(.SYNC_STAGES(SYNC_STAGES), .FILT_LEN(FILT_LEN)) u_scl_filt (
      .clk(clk), .rst_n(rst_n), .pin_i(scl_i), .level_o(scl_f));
   i2cs_line_filter #(.SYNC_STAGES(SYNC_STAGES), .FILT_LEN(FILT_LEN)) u_sda_filt (
      .clk(clk), .rst_n(rst_n), .pin_i(sda_i), .level_o(sda_f));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         scl_d <= 1'b1;
         sda_d <= 1'b1;
      end else begin
         scl_d <= scl_f;
         sda_d <= sda_f;
      end
   end

   logic ctl_en, ctl_sta, ctl_sto, ctl_aa, ctl_si, stretch;
   logic start_det, stop_det, scl_rise, scl_fall;

   assign start_det = ctl_en && scl_f && scl_d && sda_d && !sda_f;
   assign stop_det  = ctl_en && scl_f && scl_d && !sda_d && sda_f;
   assign scl_rise  = scl_f && !scl_d;
   assign scl_fall  = !scl_f && scl_d;

   // register port decode
   logic wr_cset, wr_cclr, wr_data;
   assign wr_cset = reg_we && (reg_addr == REG_AW'(REG_CSET));
   assign wr_cclr = reg_we && (reg_addr == REG_AW'(REG_CCLR));
   assign wr_data = reg_we && (reg_addr == REG_AW'(REG_DATA));

   logic [NUM_SLOTS-1:0][7:0] addr_q;
   logic [NUM_SLOTS-1:0][7:0] mask_q;
   logic [NUM_SLOTS-1:0][6:0] mask_bits;

   for (genvar i = 0; i < NUM_SLOTS; i++) begin : g_mask
      assign mask_bits[i] = mask_q[i][7:1];
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ctl_en  <= 1'b0;
         ctl_sta <= 1'b0;
         ctl_sto <= 1'b0;
         ctl_aa  <= 1'b0;
         addr_q  <= '0;
         mask_q  <= '0;
      end else begin
         if (wr_cset) begin
            if (reg_wdata[CTL_EN])  ctl_en  <= 1'b1;
            if (reg_wdata[CTL_STA]) ctl_sta <= 1'b1;
            if (reg_wdata[CTL_STO]) ctl_sto <= 1'b1;
            if (reg_wdata[CTL_AA])  ctl_aa  <= 1'b1;
         end
         if (wr_cclr) begin
            if (reg_wdata[CTL_EN])  ctl_en  <= 1'b0;
            if (reg_wdata[CTL_STA]) ctl_sta <= 1'b0;
            if (reg_wdata[CTL_STO]) ctl_sto <= 1'b0;
            if (reg_wdata[CTL_AA])  ctl_aa  <= 1'b0;
         end
         for (int i = 0; i < NUM_SLOTS; i++) begin
            if (reg_we && reg_addr == REG_AW'(REG_SLOT0 + i))             addr_q[i] <= reg_wdata;
            if (reg_we && reg_addr == REG_AW'(REG_SLOT0 + NUM_SLOTS + i)) mask_q[i] <= reg_wdata;
         end
      end
   end

   // address comparison
   logic [7:0] shift_q;
   logic       own_hit, gc_hit;

   i2cs_addr_match #(.NUM_SLOTS(NUM_SLOTS)) u_match (
      .rx_byte(shift_q), .slot_addr(addr_q), .slot_mask(mask_bits),
      .own_hit(own_hit), .gc_hit(gc_hit));

   // bus sequencer, flag and status
   bus_state_e state;
   logic [3:0] bitcnt;
   logic       is_gc, ack_q, addressed;
   logic [7:0] status_q, data_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state     <= ST_IDLE;
         bitcnt    <= '0;
         shift_q   <= '0;
         is_gc     <= 1'b0;
         ack_q     <= 1'b0;
         addressed <= 1'b0;
         sda_oe    <= 1'b0;
         ctl_si    <= 1'b0;
         stretch   <= 1'b0;
         status_q  <= STAT_NONE;
         data_q    <= '0;
      end else begin
         if (wr_data) data_q <= reg_wdata;
         if (wr_cclr && reg_wdata[CTL_SI]) begin
            ctl_si   <= 1'b0;
            stretch  <= 1'b0;
            status_q <= STAT_NONE;
         end
         if (!ctl_en) begin
            state     <= ST_IDLE;
            sda_oe    <= 1'b0;
            addressed <= 1'b0;
            stretch   <= 1'b0;
         end else if (start_det || stop_det) begin
            if (addressed) begin
               ctl_si   <= 1'b1;
               stretch  <= 1'b0;
               status_q <= STAT_STOP;
            end
            addressed <= 1'b0;
            sda_oe    <= 1'b0;
            bitcnt    <= '0;
            state     <= start_det ? ST_ADDR : ST_IDLE;
         end else begin
            unique case (state)
               ST_ADDR, ST_RX: begin
                  if (scl_rise) begin
                     shift_q <= {shift_q[6:0], sda_f};
                     bitcnt  <= bitcnt + 4'd1;
                  end else if (scl_fall && bitcnt == 4'd8) begin
                     if (state == ST_RX) begin
                        data_q <= shift_q;
                        ack_q  <= ctl_aa;
                        sda_oe <= ctl_aa;
                        state  <= ST_RX_ACK;
                     end else if (ctl_aa && (own_hit || gc_hit)) begin
                        is_gc  <= !own_hit;
                        sda_oe <= 1'b1;
                        state  <= ST_ADDR_ACK;
                     end else begin
                        state  <= ST_IDLE;
                     end
                  end
               end
               ST_ADDR_ACK: if (scl_fall) begin
                  sda_oe    <= 1'b0;
                  ctl_si    <= 1'b1;
                  stretch   <= 1'b1;
                  addressed <= 1'b1;
                  bitcnt    <= '0;
                  status_q  <= is_gc ? STAT_GC : (shift_q[0] ? STAT_OWN_R : STAT_OWN_W);
                  state     <= shift_q[0] ? ST_TX_LOAD : ST_RX;
               end
               ST_RX_ACK: if (scl_fall) begin
                  sda_oe   <= 1'b0;
                  ctl_si   <= 1'b1;
                  stretch  <= 1'b1;
                  bitcnt   <= '0;
                  status_q <= is_gc ? (ack_q ? STAT_GC_RX_ACK : STAT_GC_RX_NACK)
                                    : (ack_q ? STAT_RX_ACK : STAT_RX_NACK);
                  if (!ack_q) addressed <= 1'b0;
                  state    <= ack_q ? ST_RX : ST_IDLE;
               end
               ST_TX_LOAD: if (!ctl_si) begin
                  shift_q <= data_q;
                  sda_oe  <= ~data_q[7];
                  bitcnt  <= '0;
                  state   <= ST_TX;
               end
               ST_TX: if (scl_fall) begin
                  if (bitcnt == 4'd7) begin
                     sda_oe <= 1'b0;
                     state  <= ST_TX_ACK;
                  end else begin
                     shift_q <= {shift_q[6:0], 1'b0};
                     sda_oe  <= ~shift_q[6];
                     bitcnt  <= bitcnt + 4'd1;
                  end
               end
               ST_TX_ACK: begin
                  if (scl_rise) ack_q <= !sda_f;
                  else if (scl_fall) begin
                     ctl_si   <= 1'b1;
                     stretch  <= 1'b1;
                     status_q <= ack_q ? STAT_TX_ACK : STAT_TX_NACK;
                     if (!ack_q) addressed <= 1'b0;
                     state    <= ack_q ? ST_TX_LOAD : ST_IDLE;
                  end
               end
               default: ;
            endcase
         end
      end
   end

   assign scl_oe = (ctl_si && stretch) || (state == ST_TX_LOAD);
   assign irq    = ctl_si;

   always_comb begin
      reg_rdata = '0;
      if (reg_addr == REG_AW'(REG_CSET))
         reg_rdata = {1'b0, ctl_en, ctl_sta, ctl_sto, ctl_si, ctl_aa, 2'b00};
      if (reg_addr == REG_AW'(REG_STAT)) reg_rdata = status_q;
      if (reg_addr == REG_AW'(REG_DATA)) reg_rdata = data_q;
      for (int i = 0; i < NUM_SLOTS; i++) begin
         if (reg_addr == REG_AW'(REG_SLOT0 + i))             reg_rdata = addr_q[i];
         if (reg_addr == REG_AW'(REG_SLOT0 + NUM_SLOTS + i)) reg_rdata = mask_q[i];
      end
   end

   // checks next to the sequencer
   assert_sda_rise_scl_low_R12: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(sda_oe) |-> !scl_f);

   assert_event_has_code_R3: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(ctl_si) |-> status_q != STAT_NONE);

   assert_hold_until_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
      scl_oe && ctl_si && ctl_en && !wr_cclr |=> scl_oe);

   assert_ack_needs_aa_R10: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(sda_oe) && (state == ST_ADDR_ACK || state == ST_RX_ACK) |-> $past(ctl_aa));

   assert_idle_when_off_R10: assert property (@(posedge clk) disable iff (!rst_n)
      !ctl_en |=> !sda_oe);
endmodule

// File: tb/i2c_multi_target_tb.sv
module i2c_multi_target_tb;
   localparam int Q = 16;

   logic       clk = 1'b0;
   logic       rst_n;
   logic       scl_m, sda_m;
   logic       scl_line, sda_line;
   logic       scl_oe, sda_oe, irq;
   logic [3:0] reg_addr;
   logic       reg_we;
   logic [7:0] reg_wdata, reg_rdata;

   int checks = 0;
   int errors = 0;
   int r12_bad = 0;
   logic prev_oe = 1'b0;

   always #4 clk = ~clk;

   assign scl_line = scl_m & ~scl_oe;
   assign sda_line = sda_m & ~sda_oe;

   i2c_multi_target u_dut (
      .clk(clk), .rst_n(rst_n), .scl_i(scl_line), .sda_i(sda_line),
      .scl_oe(scl_oe), .sda_oe(sda_oe), .reg_addr(reg_addr), .reg_we(reg_we),
      .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq(irq));

   // R12 monitor: SDA drive must not move while SCL is high
   always @(negedge clk) begin
      if (rst_n && sda_oe !== prev_oe && scl_line) r12_bad++;
      prev_oe <= sda_oe;
   end

   task automatic chk(input string req, input logic [7:0] got, input logic [7:0] exp);
      checks++;
      if (got !== exp) begin
         errors++;
         $display("FAIL %s: got %02h expected %02h", req, got, exp);
      end
   endtask

   task automatic wait_clk(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic reg_wr(input logic [3:0] a, input logic [7:0] d);
      @(negedge clk);
      reg_addr = a; reg_wdata = d; reg_we = 1'b1;
      @(negedge clk);
      reg_we = 1'b0;
   endtask

   task automatic reg_rd(input logic [3:0] a, output logic [7:0] d);
      @(negedge clk);
      reg_addr = a;
      #1 d = reg_rdata;
   endtask

   task automatic clear_si;
      reg_wr(4'd1, 8'h08);
   endtask

   task automatic chk_event(input string req, input logic si_exp, input logic [7:0] st_exp);
      logic [7:0] v;
      reg_rd(4'd0, v);
      chk(req, {7'd0, v[3]}, {7'd0, si_exp});
      reg_rd(4'd2, v);
      chk(req, v, st_exp);
   endtask

   task automatic scl_up;
      scl_m = 1'b1;
      while (!scl_line) @(negedge clk);
   endtask

   task automatic m_start;
      sda_m = 1'b1; wait_clk(Q);
      scl_up;       wait_clk(Q);
      sda_m = 1'b0; wait_clk(Q);
      scl_m = 1'b0; wait_clk(Q);
   endtask

   task automatic m_stop;
      sda_m = 1'b0; wait_clk(Q);
      scl_up;       wait_clk(Q);
      sda_m = 1'b1; wait_clk(2 * Q);
   endtask

   task automatic m_bit(input logic b, output logic got);
      sda_m = b; wait_clk(Q);
      scl_up;    wait_clk(Q);
      got = sda_line;
      scl_m = 1'b0; wait_clk(Q);
   endtask

   task automatic m_wbyte(input logic [7:0] v, output logic ack_n);
      logic g;
      for (int i = 7; i >= 0; i--) m_bit(v[i], g);
      m_bit(1'b1, ack_n);
      wait_clk(Q);
   endtask

   task automatic m_rbyte(input logic nack, output logic [7:0] v);
      logic g;
      for (int i = 7; i >= 0; i--) begin
         m_bit(1'b1, g);
         v[i] = g;
      end
      m_bit(nack, g);
      wait_clk(Q);
   endtask

   task automatic t_reset;
      logic [7:0] v;
      chk("R1 scl_oe", {7'd0, scl_oe}, 8'h00);
      chk("R1 sda_oe", {7'd0, sda_oe}, 8'h00);
      chk("R1 irq", {7'd0, irq}, 8'h00);
      reg_rd(4'd0, v); chk("R1 control", v, 8'h00);
      reg_rd(4'd2, v); chk("R1 status", v, 8'hF8);
   endtask

   task automatic t_control;
      logic [7:0] v;
      reg_wr(4'd0, 8'h4C);
      reg_rd(4'd0, v); chk("R11 set ignores flag", v, 8'h44);
      reg_wr(4'd0, 8'h30);
      reg_rd(4'd0, v); chk("R11 set start/stop bits", v, 8'h74);
      reg_wr(4'd1, 8'h30);
      reg_rd(4'd0, v); chk("R11 clear bits", v, 8'h44);
   endtask

   task automatic t_receive;
      logic ack_n;
      logic [7:0] v;
      m_start;
      m_wbyte(8'hA0, ack_n);
      chk("R3 address ack", {7'd0, ack_n}, 8'h00);
      chk_event("R3 own write", 1'b1, 8'h60);
      chk("R8 hold", {7'd0, scl_oe}, 8'h01);
      wait_clk(50);
      chk("R8 still held", {7'd0, scl_oe}, 8'h01);
      clear_si;
      wait_clk(2);
      chk("R8 released", {7'd0, scl_oe}, 8'h00);
      reg_rd(4'd2, v); chk("R8 status after clear", v, 8'hF8);
      m_wbyte(8'h3C, ack_n);
      chk("R6 data ack", {7'd0, ack_n}, 8'h00);
      chk_event("R6 rx ack", 1'b1, 8'h80);
      reg_rd(4'd3, v); chk("R6 data value", v, 8'h3C);
      reg_wr(4'd1, 8'h04);
      clear_si;
      m_wbyte(8'hC5, ack_n);
      chk("R6 data nack", {7'd0, ack_n}, 8'h01);
      chk_event("R6 rx nack", 1'b1, 8'h88);
      reg_rd(4'd3, v); chk("R6 nack data value", v, 8'hC5);
      clear_si;
      reg_wr(4'd0, 8'h04);
      m_stop;
      chk_event("R9 no event when unaddressed", 1'b0, 8'hF8);
   endtask

   task automatic t_mask;
      logic ack_n;
      m_start;
      m_wbyte(8'h62, ack_n);
      chk("R3 masked hit 0x31", {7'd0, ack_n}, 8'h00);
      chk_event("R3 masked status", 1'b1, 8'h60);
      clear_si;
      m_stop;
      chk_event("R9 stop event", 1'b1, 8'hA0);
      chk("R9 stop no hold", {7'd0, scl_oe}, 8'h00);
      clear_si;
      m_start;
      m_wbyte(8'h66, ack_n);
      chk("R3 masked hit 0x33", {7'd0, ack_n}, 8'h00);
      clear_si;
      m_start;
      chk_event("R9 repeated start event", 1'b1, 8'hA0);
      clear_si;
      m_wbyte(8'h68, ack_n);
      chk("R4 unmasked miss nack", {7'd0, ack_n}, 8'h01);
      chk_event("R4 miss no event", 1'b0, 8'hF8);
      m_stop;
   endtask

   task automatic t_general_call;
      logic ack_n;
      logic [7:0] v;
      m_start;
      m_wbyte(8'h00, ack_n);
      chk("R5 gc disabled nack", {7'd0, ack_n}, 8'h01);
      chk_event("R5 gc disabled no event", 1'b0, 8'hF8);
      m_stop;
      reg_wr(4'd7, 8'hFF);
      m_start;
      m_wbyte(8'h00, ack_n);
      chk("R5 gc ack", {7'd0, ack_n}, 8'h00);
      chk_event("R5 gc status", 1'b1, 8'h70);
      clear_si;
      m_wbyte(8'h5A, ack_n);
      chk_event("R5 gc data status", 1'b1, 8'h90);
      reg_rd(4'd3, v); chk("R5 gc data value", v, 8'h5A);
      clear_si;
      m_stop;
      chk_event("R9 gc stop", 1'b1, 8'hA0);
      clear_si;
      reg_wr(4'd7, 8'hFE);
   endtask

   task automatic t_transmit;
      logic ack_n;
      logic [7:0] v;
      m_start;
      m_wbyte(8'hA1, ack_n);
      chk("R7 read address ack", {7'd0, ack_n}, 8'h00);
      chk_event("R7 own read", 1'b1, 8'hA8);
      chk("R8 read hold", {7'd0, scl_oe}, 8'h01);
      reg_wr(4'd3, 8'h96);
      clear_si;
      m_rbyte(1'b0, v);
      chk("R7 first byte", v, 8'h96);
      chk_event("R7 master ack", 1'b1, 8'hB8);
      reg_wr(4'd3, 8'h3B);
      clear_si;
      m_rbyte(1'b1, v);
      chk("R7 second byte", v, 8'h3B);
      chk_event("R7 master nack", 1'b1, 8'hC0);
      clear_si;
      m_stop;
      chk_event("R9 no event after nack", 1'b0, 8'hF8);
   endtask

   task automatic t_gating;
      logic ack_n;
      reg_wr(4'd1, 8'h40);
      m_start;
      m_wbyte(8'hA0, ack_n);
      chk("R10 disabled nack", {7'd0, ack_n}, 8'h01);
      chk_event("R10 disabled no event", 1'b0, 8'hF8);
      m_stop;
      reg_wr(4'd0, 8'h40);
      reg_wr(4'd1, 8'h04);
      m_start;
      m_wbyte(8'hA0, ack_n);
      chk("R10 aa off nack", {7'd0, ack_n}, 8'h01);
      chk_event("R10 aa off no event", 1'b0, 8'hF8);
      m_stop;
      reg_wr(4'd0, 8'h04);
   endtask

   task automatic t_glitch;
      logic ack_n;
      sda_m = 1'b0;
      wait_clk(2);
      sda_m = 1'b1;
      wait_clk(Q);
      m_wbyte(8'hA0, ack_n);
      chk("R2 glitch not a start", {7'd0, ack_n}, 8'h01);
      chk_event("R2 glitch no event", 1'b0, 8'hF8);
      m_stop;
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      checks++;
      errors++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      rst_n = 1'b0; scl_m = 1'b1; sda_m = 1'b1;
      reg_we = 1'b0; reg_addr = '0; reg_wdata = '0;
      wait_clk(5);
      rst_n = 1'b1;
      wait_clk(5);
      t_reset;
      t_control;
      reg_wr(4'd4, 8'hA0);  reg_wr(4'd8, 8'h00);
      reg_wr(4'd5, 8'h60);  reg_wr(4'd9, 8'h06);
      reg_wr(4'd6, 8'h24);  reg_wr(4'd10, 8'h00);
      reg_wr(4'd7, 8'hFE);  reg_wr(4'd11, 8'h00);
      wait_clk(Q);
      t_receive;
      t_mask;
      t_general_call;
      t_transmit;
      t_gating;
      t_glitch;
      chk("R12 sda moves only with scl low", r12_bad[7:0], 8'h00);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule